// File: doc/BRIEF.md
# Scanline Sprite Line Renderer

This block builds one horizontal line of sprite pixels at a time. When a new line is requested it wipes its internal 256-pixel line buffer. It then walks the whole sprite attribute list. Each list entry takes four bytes. For every entry whose vertical extent includes the requested line, the block works out pattern-ROM byte addresses and extracts 4-bit pixels from those bytes. Opaque pixels are written into the buffer with a sprite colour tag added. Once the last entry has been handled, a single-cycle completion pulse is raised. The display side can read the finished line through a combinational read port.

Both memories are external. The attribute RAM and the pattern ROM each return their data on the clock after the address is presented. Sprites can be flipped vertically and horizontally, and a double-width mode joins a second 16-pixel half to the first.

Top module: `sprite_line_renderer`

## Requirements
- R1: After synchronous reset, `busy` and `done` are low and every buffer pixel reads 0.
- R2: `line_start` while idle clears all buffer pixels to 0 and starts a scan of the line given on `line_num`. `line_start` while busy has no effect on the scan or its result.
- R3: Entry `e` occupies attribute addresses 4e..4e+3. Byte 1 holds the inverted Y position. An entry hits when the 8-bit wrapped difference (line − un-inverted Y) is ≤ the 5-bit size in byte 0 bits 4:0. Entries that miss write nothing.
- R4: Byte 0 bit 7 is vertical flip and byte 2 is the tile. The ROM address is formed as {tile[7:2], A8, A7, row[3:0], cnt[3:1]}. Here row = difference[3:0], inverted under vertical flip. A7 = NOT(NOT((vflip XOR diff[4]) AND size[4]) AND tile[0]). A8 = tile[1] XOR (dwide AND NOT hflip).
- R5: Byte 0 bit 6 is horizontal flip. For column i (0..15), cnt = i, or i XOR 15 when the flip is set.
- R6: An odd cnt takes the ROM byte's low nibble and an even cnt takes the high nibble. Nibbles 0 and 15 are transparent. Any other nibble n is written as n OR 0x10 at X + column, where X is byte 3.
- R7: Byte 0 bit 5 selects double width. A second half is fetched at the address with bit 8 toggled and written at X + 16 + i.
- R8: Pixels whose position exceeds 255 are dropped and never wrap.
- R9: Where two entries write the same pixel, the entry with the higher index wins.
- R10: `done` is a one-cycle pulse, and `busy` drops in the same cycle. A scan takes exactly the sum over all entries of 7 cycles plus 16 cycles per hitting single-width entry or 32 per hitting double-width entry.
- R11: `rom_data` is taken exactly one cycle after its address appears on `rom_addr`. The same holds for `attr_data` relative to `attr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Start rendering a line (honoured when idle) |
| line_num | input | 8 | Line number to render |
| attr_addr | output | ENTRY_W+2 | Attribute RAM byte address |
| attr_data | input | 8 | Attribute RAM read data, one cycle latency |
| rom_addr | output | 15 | Pattern ROM byte address |
| rom_data | input | 8 | Pattern ROM read data, one cycle latency |
| rd_x | input | 8 | Line buffer read position |
| rd_pix | output | 5 | Line buffer pixel at `rd_x` |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
The bench targets the hit-window edges: a difference exactly equal to the size, one past it, and a Y above the line whose difference wraps to a small value. A design using an inclusive-versus-exclusive compare that is off by one, or using signed arithmetic, would gain or lose a whole sprite row. Tiles with both low bits set are mixed with sizes of 16 or more under both flip states. This exposes any swapped term in the A7/A8 logic, which would pull pixels from the wrong ROM quarter. Sprites near X = 255 check that columns are clipped rather than wrapped onto the left edge. Overlapping entries check that the later entry wins. A start pulse injected mid-scan, and a blank line rendered after a busy one, check that a restart or a missed clear would leave stale pixels.

// File: rtl/slr_pkg.sv
package slr_pkg;

    localparam int BYTE_W  = 8;
    localparam int NIB_W   = 4;
    localparam int XW      = 8;
    localparam int PIX_W   = NIB_W + 1;
    localparam int ROM_AW  = 15;
    localparam int HALF_PX = 16;
    localparam int FCNT_W  = 5;

    localparam logic [PIX_W-1:0] SPR_TAG = PIX_W'(5'h10);

    // Entry fields in byte order: flags/size, inverted Y, tile, X.
    typedef struct packed {
        logic              vflip;
        logic              hflip;
        logic              dwide;
        logic [4:0]        vsize;
        logic [BYTE_W-1:0] ypos_n;
        logic [BYTE_W-1:0] tile;
        logic [BYTE_W-1:0] xpos;
    } spr_attr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ATTR,
        ST_EVAL,
        ST_PIX,
        ST_NEXT
    } scan_st_e;

    typedef struct packed {
        logic          lo_nib;
        logic [XW:0]   x;
    } fetch_tag_t;

    function automatic logic [BYTE_W-1:0] spr_row_delta(
        input logic [BYTE_W-1:0] line,
        input spr_attr_t         a
    );
        logic [BYTE_W-1:0] ytop;
        ytop = ~a.ypos_n;
        return line - ytop;
    endfunction

    function automatic logic spr_covers(
        input logic [BYTE_W-1:0] delta,
        input spr_attr_t         a
    );
        return delta <= {3'b000, a.vsize};
    endfunction

    function automatic logic [ROM_AW-1:0] spr_rom_addr(
        input spr_attr_t         a,
        input logic [BYTE_W-1:0] delta,
        input logic [3:0]        cnt,
        input logic              second
    );
        logic       bit7;
        logic       bit8;
        logic [3:0] row;
        bit8 = a.tile[1] ^ (a.dwide & ~a.hflip);
        bit7 = ~(~((a.vflip ^ delta[4]) & a.vsize[4]) & a.tile[0]);
        row  = a.vflip ? ~delta[3:0] : delta[3:0];
        return {a.tile[7:2], bit8 ^ second, bit7, row, cnt[3:1]};
    endfunction

    function automatic logic [NIB_W-1:0] nib_pick(
        input logic [BYTE_W-1:0] data,
        input logic              lo
    );
        return lo ? data[3:0] : data[7:4];
    endfunction

    function automatic logic nib_opaque(input logic [NIB_W-1:0] n);
        return (n != '0) && (n != '1);
    endfunction

endpackage

// File: rtl/slr_addr_gen.sv
module slr_addr_gen
    import slr_pkg::*;
(
    input  spr_attr_t                 attr,
    input  logic [BYTE_W-1:0]         line,
    input  logic [FCNT_W-1:0]         fcnt,
    output logic                      hit,
    output logic                      last,
    output logic [ROM_AW-1:0]         rom_addr,
    output fetch_tag_t                tag
);

    logic [BYTE_W-1:0] delta;
    logic [3:0]        col;
    logic [3:0]        cnt;
    logic              second;

    always_comb begin
        delta    = spr_row_delta(line, attr);
        hit      = spr_covers(delta, attr);
        col      = fcnt[3:0];
        second   = fcnt[FCNT_W-1];
        cnt      = attr.hflip ? ~col : col;
        last     = attr.dwide ? (fcnt == FCNT_W'(2*HALF_PX-1))
                              : (fcnt == FCNT_W'(HALF_PX-1));
        rom_addr = spr_rom_addr(attr, delta, cnt, second);
        tag.lo_nib = cnt[0];
        tag.x      = {1'b0, attr.xpos} + (XW+1)'(fcnt);
    end

endmodule

// File: rtl/slr_pix_pipe.sv
module slr_pix_pipe
    import slr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  fetch_tag_t        tag_in,
    input  logic [BYTE_W-1:0] rom_data,
    output logic              wr_en,
    output logic [XW-1:0]     wr_x,
    output logic [PIX_W-1:0]  wr_val
);

    logic       vld_q;
    fetch_tag_t tag_q;
    logic [NIB_W-1:0] nib;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            tag_q <= '0;
        end else begin
            vld_q <= issue;
            if (issue) tag_q <= tag_in;
        end
    end

    always_comb begin
        nib    = nib_pick(rom_data, tag_q.lo_nib);
        wr_en  = vld_q && nib_opaque(nib) && !tag_q.x[XW];
        wr_x   = tag_q.x[XW-1:0];
        wr_val = SPR_TAG | PIX_W'(nib);
    end

endmodule

// File: rtl/slr_line_buf.sv
module slr_line_buf
    import slr_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] wa,
    input  logic [PIX_W-1:0]         wd,
    input  logic [$clog2(DEPTH)-1:0] ra,
    output logic [PIX_W-1:0]         rd
);

    logic [PIX_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd = mem[ra];

endmodule

// File: rtl/sprite_line_renderer.sv
module sprite_line_renderer
    import slr_pkg::*;
#(
    parameter int ENTRY_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_start,
    input  logic [7:0]           line_num,
    output logic [ENTRY_W+1:0]   attr_addr,
    input  logic [7:0]           attr_data,
    output logic [14:0]          rom_addr,
    input  logic [7:0]           rom_data,
    input  logic [7:0]           rd_x,
    output logic [4:0]           rd_pix,
    output logic                 busy,
    output logic                 done
);

    localparam int BYTES_PER = 4;
    localparam int BC_W      = $clog2(BYTES_PER) + 1;
    localparam int LINE_PX   = 1 << XW;
    localparam logic [ENTRY_W-1:0] LAST_IDX = '1;

    scan_st_e            st_q;
    logic [ENTRY_W-1:0]  idx_q;
    logic [BC_W-1:0]     bc_q;
    logic [FCNT_W-1:0]   fcnt_q;
    logic [BYTE_W-1:0]   line_q;
    spr_attr_t           attr_q;
    logic                done_q;

    logic                hit;
    logic                last;
    fetch_tag_t          tag;
    logic                issue;
    logic                clr;
    logic                wr_en;
    logic [XW-1:0]       wr_x;
    logic [PIX_W-1:0]    wr_val;

    slr_addr_gen u_addr (
        .attr     (attr_q),
        .line     (line_q),
        .fcnt     (fcnt_q),
        .hit      (hit),
        .last     (last),
        .rom_addr (rom_addr),
        .tag      (tag)
    );

    assign issue = (st_q == ST_PIX);
    assign clr   = (st_q == ST_IDLE) && line_start;

    slr_pix_pipe u_pipe (
        .clk      (clk),
        .rst      (rst),
        .issue    (issue),
        .tag_in   (tag),
        .rom_data (rom_data),
        .wr_en    (wr_en),
        .wr_x     (wr_x),
        .wr_val   (wr_val)
    );

    slr_line_buf #(.DEPTH(LINE_PX)) u_buf (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .we  (wr_en),
        .wa  (wr_x),
        .wd  (wr_val),
        .ra  (rd_x),
        .rd  (rd_pix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            bc_q   <= '0;
            fcnt_q <= '0;
            line_q <= '0;
            attr_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (line_start) begin
                        line_q <= line_num;
                        idx_q  <= '0;
                        bc_q   <= '0;
                        st_q   <= ST_ATTR;
                    end
                end
                ST_ATTR: begin
                    bc_q <= bc_q + 1'b1;
                    unique case (bc_q)
                        BC_W'(1): attr_q[31:24] <= attr_data;
                        BC_W'(2): attr_q[23:16] <= attr_data;
                        BC_W'(3): attr_q[15:8]  <= attr_data;
                        BC_W'(4): attr_q[7:0]   <= attr_data;
                        default: ;
                    endcase
                    if (bc_q == BC_W'(BYTES_PER)) st_q <= ST_EVAL;
                end
                ST_EVAL: begin
                    fcnt_q <= '0;
                    st_q   <= hit ? ST_PIX : ST_NEXT;
                end
                ST_PIX: begin
                    fcnt_q <= fcnt_q + 1'b1;
                    if (last) st_q <= ST_NEXT;
                end
                ST_NEXT: begin
                    bc_q <= '0;
                    if (idx_q == LAST_IDX) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= ST_ATTR;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign attr_addr = {idx_q, bc_q[1:0]};
    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;

endmodule

// File: rtl/slr_checker.sv
module slr_checker (
    input logic       clk,
    input logic       rst,
    input logic       line_start,
    input logic       busy,
    input logic       done,
    input logic [4:0] rd_pix
);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_done_after_scan_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

    p_start_runs_r2: assert property (@(posedge clk) disable iff (rst)
        (line_start && !busy) |=> busy);

    p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && line_start) |=> (busy || done));

    p_pix_tag_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_pix != 5'd0) |-> rd_pix[4]);

endmodule

bind sprite_line_renderer slr_checker u_slr_checker (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .busy       (busy),
    .done       (done),
    .rd_pix     (rd_pix)
);

// File: tb/test_sprite_line_renderer.sv
module test_sprite_line_renderer;

    localparam int NE = 256;

    logic        clk = 1'b0;
    logic        rst;
    logic        line_start;
    logic [7:0]  line_num;
    logic [9:0]  attr_addr;
    logic [7:0]  attr_data;
    logic [14:0] rom_addr;
    logic [7:0]  rom_data;
    logic [7:0]  rd_x;
    logic [4:0]  rd_pix;
    logic        busy;
    logic        done;

    always #5 clk = ~clk;

    sprite_line_renderer i_sprite_line_renderer (
        .clk(clk), .rst(rst), .line_start(line_start), .line_num(line_num),
        .attr_addr(attr_addr), .attr_data(attr_data),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .rd_x(rd_x), .rd_pix(rd_pix), .busy(busy), .done(done)
    );

    logic [7:0] attr_mem [0:4*NE-1];
    int exp_line [0:255];
    int exp_cycles;
    int errors = 0;
    int checks = 0;

    function automatic logic [7:0] rom_fn(input logic [14:0] a);
        logic [23:0] t;
        t = {9'b0, a} * 24'd40503;
        return t[15:8] ^ a[7:0] ^ {a[14:12], a[4:0]};
    endfunction

    // Memory models: one cycle read latency (R11)
    always @(posedge clk) begin
        rom_data  <= rom_fn(rom_addr);
        attr_data <= attr_mem[attr_addr];
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic all_off();
        for (int e = 0; e < NE; e++) begin
            attr_mem[4*e]   = 8'h00;
            attr_mem[4*e+1] = ~8'd200;
            attr_mem[4*e+2] = 8'h00;
            attr_mem[4*e+3] = 8'h00;
        end
    endtask

    task automatic set_spr(input int e, input bit vf, input bit hf, input bit dw,
                           input int vs, input int y, input int tile, input int x);
        attr_mem[4*e]   = {vf, hf, dw, vs[4:0]};
        attr_mem[4*e+1] = ~y[7:0];
        attr_mem[4*e+2] = tile[7:0];
        attr_mem[4*e+3] = x[7:0];
    endtask

    task automatic build_exp(input int line);
        int b0, tile, xpos, y, diff, vs, vf, hf, dw, w, i, half, cnt, row;
        int a7, a8, addr, byt, nib, x;
        for (int p = 0; p < 256; p++) exp_line[p] = 0;
        exp_cycles = 0;
        for (int e = 0; e < NE; e++) begin
            b0   = int'(attr_mem[4*e]);
            y    = int'(~attr_mem[4*e+1]);
            tile = int'(attr_mem[4*e+2]);
            xpos = int'(attr_mem[4*e+3]);
            vf = (b0 >> 7) & 1; hf = (b0 >> 6) & 1; dw = (b0 >> 5) & 1;
            vs = b0 & 31;
            diff = (line - y) & 255;
            exp_cycles += 7;
            if (diff <= vs) begin
                w = dw ? 32 : 16;
                exp_cycles += w;
                for (int k = 0; k < w; k++) begin
                    i = k % 16; half = k / 16;
                    cnt = hf ? (i ^ 15) : i;
                    row = diff & 15;
                    if (vf != 0) row = row ^ 15;
                    a7 = 1 - ((1 - ((vf ^ ((diff >> 4) & 1)) & ((vs >> 4) & 1))) & (tile & 1));
                    a8 = ((tile >> 1) & 1) ^ ((hf & dw) ^ dw);
                    addr = ((tile >> 2) << 9) | (a8 << 8) | (a7 << 7) | (row << 3) | (cnt >> 1);
                    if (half != 0) addr = addr ^ 256;
                    byt = int'(rom_fn(addr[14:0]));
                    nib = (cnt & 1) ? (byt & 15) : (byt >> 4);
                    x = xpos + k;
                    if (nib != 0 && nib != 15 && x < 256) exp_line[x] = nib | 16;
                end
            end
        end
    endtask

    task automatic run_line(input string req, input int line, input bit poke);
        int n;
        build_exp(line);
        @(negedge clk);
        line_num   = line[7:0];
        line_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        line_start = 1'b0;
        n = 0;
        while (n < 30000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (poke && n == 20) begin
                line_start = 1'b1;
                line_num   = line[7:0] + 8'd3;
            end else begin
                line_start = 1'b0;
            end
            if (done) break;
        end
        chk("R10", "scan cycles", n, exp_cycles);
        @(negedge clk);
        chk("R10", "done pulse width", int'(done), 0);
        chk("R10", "busy after done", int'(busy), 0);
        for (int x = 0; x < 256; x++) begin
            rd_x = x[7:0];
            #1;
            chk(req, $sformatf("pixel x=%0d line=%0d", x, line), int'(rd_pix), exp_line[x]);
        end
    endtask

    initial begin
        rst = 1'b1; line_start = 1'b0; line_num = 8'd0; rd_x = 8'd0;
        all_off();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        for (int x = 0; x < 256; x += 85) begin
            rd_x = x[7:0];
            #1;
            chk("R1", $sformatf("pixel x=%0d", x), int'(rd_pix), 0);
        end

        // R3: hit window edges
        all_off();
        set_spr(3, 0, 0, 0, 0, 50, 8'h08, 10);
        set_spr(7, 0, 0, 0, 5, 45, 8'h09, 60);
        set_spr(9, 0, 0, 0, 5, 44, 8'h0A, 110);
        set_spr(12, 0, 0, 0, 31, 52, 8'h0B, 160);
        run_line("R3", 50, 1'b0);

        // R3: wrapped difference
        all_off();
        set_spr(40, 0, 0, 0, 10, 250, 8'h57, 70);
        set_spr(41, 0, 0, 0, 8, 250, 8'h58, 120);
        run_line("R3", 3, 1'b0);

        // R4: vertical flip, A7/A8 terms
        all_off();
        set_spr(1, 1, 0, 0, 20, 30, 8'h5D, 10);
        set_spr(2, 0, 0, 0, 20, 30, 8'h5D, 40);
        set_spr(3, 1, 0, 0, 20, 40, 8'hA7, 80);
        set_spr(4, 0, 0, 0, 3, 48, 8'hFE, 120);
        set_spr(5, 1, 0, 0, 7, 47, 8'h33, 160);
        set_spr(6, 0, 0, 0, 25, 31, 8'h0F, 200);
        run_line("R4", 50, 1'b0);

        // R5 and R6: horizontal flip, nibble selection, transparency
        all_off();
        set_spr(0, 0, 1, 0, 0, 50, 8'h21, 30);
        set_spr(200, 1, 1, 0, 9, 45, 8'h66, 90);
        set_spr(255, 0, 0, 0, 2, 49, 8'hC4, 150);
        run_line("R5", 50, 1'b0);
        run_line("R6", 50, 1'b0);

        // R7: double width
        all_off();
        set_spr(10, 0, 0, 1, 0, 50, 8'h12, 5);
        set_spr(11, 0, 1, 1, 4, 47, 8'h47, 60);
        set_spr(12, 1, 1, 1, 17, 40, 8'h9B, 120);
        run_line("R7", 50, 1'b0);

        // R8: right edge clipping
        all_off();
        set_spr(5, 0, 0, 0, 0, 50, 8'h31, 250);
        set_spr(6, 0, 0, 1, 0, 50, 8'h44, 235);
        run_line("R8", 50, 1'b0);

        // R9: later entry wins
        all_off();
        set_spr(20, 0, 0, 0, 0, 50, 8'h10, 100);
        set_spr(21, 0, 0, 0, 0, 50, 8'h88, 104);
        set_spr(22, 0, 1, 1, 0, 50, 8'h3C, 90);
        run_line("R9", 50, 1'b0);

        // R11: dense pseudo-random list
        for (int e = 0; e < NE; e++) begin
            attr_mem[4*e]   = 8'($urandom);
            attr_mem[4*e+1] = ~(8'd77 - 8'($urandom % 24));
            attr_mem[4*e+2] = 8'($urandom);
            attr_mem[4*e+3] = 8'($urandom);
        end
        run_line("R11", 77, 1'b0);

        // R2: start pulse during a scan is ignored
        run_line("R2", 77, 1'b1);

        // R2: buffer cleared before a new line
        all_off();
        run_line("R2", 50, 1'b0);

        summary();
        $finish;
    end

endmodule